// File: doc/BRIEF.md
# Two-Stage Watchdog Timer with Interrupt Auto-Clear

A countdown watchdog whose system reset needs two expiries in a row. The counter steps down once per `tick_i` pulse. Each time it expires it reloads from the period register and keeps counting. The first expiry sets an expire flag in the status register. A reset pulse is issued only when the counter expires again while that flag is still set and nothing has cleared it. As a result, the time from the last service to reset lies between one period and two periods.

Firmware can keep the reset from ever firing by setting the auto-clear enable in the interrupt control register. With that bit set, every expiry raises a one-cycle system-management interrupt request, and the request itself clears the expire flag. Software takes over by clearing the enable bit. From then on it must pulse `kick_i` to reload the counter, and it must write 1 to the expire flag to clear it.

The register bus is a single-cycle write port with a combinational read port. The bus has four word addresses: interrupt control, status, period and the current count (read-only).

Top module: `wdg_twostage`

## Requirements
- R1: After `rst_ni` is released, `smi_o` and `sys_rst_o` are 0. Reads return the following values: control (address 0) reads 0x2000, because the auto-clear bit 13 is set; status (address 1) reads 0; period (address 2) and count (address 3) both read PERIOD_RST.
- R2: On a clock edge where `tick_i` is 1, `kick_i` is 0, no reset pulse is active and the count is non-zero, the count decreases by exactly one. On an edge where `tick_i` is 0, the count is unchanged.
- R3: A tick that arrives while the count is 0 is an expiry, and the count reloads with the period. A programmed period of 0 reloads as 1. From a reload to period P, the expiry falls on tick P+1.
- R4: With control bit 13 clear, an expiry that finds the expire flag clear sets status bit 3 on that edge. It raises no `smi_o` and no `sys_rst_o`.
- R5: Writing status with bit 3 = 1 clears the expire flag, and writing 0 there has no effect. An expiry on the same edge as a clearing write leaves the flag set.
- R6: With bit 13 clear, an expiry while the flag is set drives `sys_rst_o` high for exactly RST_CYCLES cycles, starting after that edge. When the pulse ends, the count equals the reload value and the flag is clear. Control and period keep their values.
- R7: With bit 13 set, every expiry drives `smi_o` high for exactly one cycle after the expiry edge, with status bit 3 reading 1 in that cycle. The flag is clear in the next cycle. `sys_rst_o` never rises, even if the flag was already set.
- R8: `kick_i` reloads the count with the period. When it coincides with an expiry, the kick wins: no flag is set, there is no `smi_o` and there is no reset.
- R9: While `sys_rst_o` is high, `tick_i` and `kick_i` are ignored and the count holds.
- R10: Writing the period register does not change the current count. The new value is used at the next reload.
- R11: With bit 13 clear, reset fires 2(P+1) ticks after a kick if the flag was clear at the kick. It fires P+1 ticks after the kick if the flag was left set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register word address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, combinational from the address |
| kick_i | input | 1 | Keepalive: reload the counter |
| tick_i | input | 1 | Count enable, one decrement per pulse |
| smi_o | output | 1 | Interrupt request pulse for auto-clear |
| sys_rst_o | output | 1 | System reset pulse |

## Verification
Every result is due one cycle after its stimulus, so the bench samples 1 ns after the rising edge that applied the stimulus:
- Count and status reads reflect that edge at once.
- `smi_o` appears in the single cycle after the expiry edge, and the flag clear is seen one cycle later.
- The bench counts `sys_rst_o` high for RST_CYCLES consecutive sampled cycles, with the first one right after the second expiry edge.

For the P+1 and 2(P+1) windows, the bench checks the reset output after every tick, so an early or late trigger is caught on the exact tick. In the random phase, a bench model predicts the count and the interrupt pulse for each cycle, and the bench compares them with the design at the same sample point.

// File: rtl/wdg_twostage_pkg.sv
package wdg_twostage_pkg;
  localparam int unsigned DATA_W       = 32;
  localparam int unsigned ADDR_W       = 2;
  localparam int unsigned SMI_CLR_BIT  = 13;
  localparam int unsigned EXP_FLAG_BIT = 3;

  typedef enum logic [ADDR_W-1:0] {
    REG_SMICTL = 2'd0,
    REG_STATUS = 2'd1,
    REG_PERIOD = 2'd2,
    REG_COUNT  = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/wdg_twostage_regs.sv
module wdg_twostage_regs
  import wdg_twostage_pkg::*;
#(
  parameter int unsigned CNT_W      = 16,
  parameter int unsigned PERIOD_RST = 20
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              flag_i,
  input  logic [CNT_W-1:0]  cnt_i,
  output logic [CNT_W-1:0]  period_o,
  output logic              auto_clr_o,
  output logic              flag_w1c_o
);
  logic [CNT_W-1:0] period_q;
  logic             auto_clr_q;
  reg_addr_e        addr;

  assign addr = reg_addr_e'(addr_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      period_q   <= CNT_W'(PERIOD_RST);
      auto_clr_q <= 1'b1;
    end else if (we_i) begin
      if (addr == REG_SMICTL) auto_clr_q <= wdata_i[SMI_CLR_BIT];
      if (addr == REG_PERIOD) period_q   <= wdata_i[CNT_W-1:0];
    end
  end

  assign flag_w1c_o = we_i && (addr == REG_STATUS) && wdata_i[EXP_FLAG_BIT];

  always_comb begin
    rdata_o = '0;
    case (addr)
      REG_SMICTL: rdata_o[SMI_CLR_BIT]  = auto_clr_q;
      REG_STATUS: rdata_o[EXP_FLAG_BIT] = flag_i;
      REG_PERIOD: rdata_o[CNT_W-1:0]    = period_q;
      REG_COUNT:  rdata_o[CNT_W-1:0]    = cnt_i;
      default:    rdata_o = '0;
    endcase
  end

  logic unused_wdata;
  assign unused_wdata = ^wdata_i;

  assign period_o   = period_q;
  assign auto_clr_o = auto_clr_q;
endmodule

// File: rtl/wdg_twostage_cnt.sv
module wdg_twostage_cnt #(
  parameter int unsigned CNT_W      = 16,
  parameter int unsigned PERIOD_RST = 20
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             kick_i,
  input  logic             hold_i,
  input  logic             restore_i,
  input  logic [CNT_W-1:0] period_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] reload_o,
  output logic             expire_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] reload;

  // zero period would expire every tick; floor it at one
  assign reload   = (period_i == '0) ? CNT_W'(1) : period_i;
  assign expire_o = tick_i && !kick_i && !hold_i && (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= CNT_W'(PERIOD_RST);
    end else if (restore_i) begin
      cnt_q <= reload;
    end else if (!hold_i) begin
      if (kick_i)                 cnt_q <= reload;
      else if (tick_i) begin
        if (cnt_q == '0)          cnt_q <= reload;
        else                      cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  assign cnt_o    = cnt_q;
  assign reload_o = reload;
endmodule

// File: rtl/wdg_twostage_seq.sv
module wdg_twostage_seq #(
  parameter int unsigned RST_CYCLES = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic expire_i,
  input  logic auto_clr_i,
  input  logic flag_w1c_i,
  output logic flag_o,
  output logic smi_o,
  output logic sys_rst_o,
  output logic restore_o
);
  localparam int unsigned LW = (RST_CYCLES < 2) ? 1 : $clog2(RST_CYCLES);

  logic          flag_q;
  logic          smi_q;
  logic          rst_q;
  logic [LW-1:0] left_q;
  logic          trig;
  logic          flag_clr;

  assign trig      = expire_i && flag_q && !auto_clr_i;
  assign restore_o = rst_q && (left_q == '0);
  assign flag_clr  = flag_w1c_i || smi_q || restore_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q <= 1'b0;
      smi_q  <= 1'b0;
    end else begin
      smi_q <= expire_i && auto_clr_i;
      // a new expiry outranks any clear on the same edge
      if (expire_i)      flag_q <= 1'b1;
      else if (flag_clr) flag_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_q  <= 1'b0;
      left_q <= '0;
    end else if (trig) begin
      rst_q  <= 1'b1;
      left_q <= LW'(RST_CYCLES - 1);
    end else if (rst_q) begin
      if (left_q == '0) rst_q  <= 1'b0;
      else              left_q <= left_q - 1'b1;
    end
  end

  assign flag_o    = flag_q;
  assign smi_o     = smi_q;
  assign sys_rst_o = rst_q;
endmodule

// File: rtl/wdg_twostage.sv
module wdg_twostage
  import wdg_twostage_pkg::*;
#(
  parameter int unsigned CNT_W      = 16,
  parameter int unsigned PERIOD_RST = 20,
  parameter int unsigned RST_CYCLES = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  input  logic              kick_i,
  input  logic              tick_i,
  output logic              smi_o,
  output logic              sys_rst_o
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] period;
  logic [CNT_W-1:0] reload_val;
  logic             auto_clr;
  logic             flag_w1c;
  logic             flag;
  logic             expire;
  logic             restore;

  wdg_twostage_regs #(.CNT_W(CNT_W), .PERIOD_RST(PERIOD_RST)) i_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (reg_we_i),
    .addr_i     (reg_addr_i),
    .wdata_i    (reg_wdata_i),
    .rdata_o    (reg_rdata_o),
    .flag_i     (flag),
    .cnt_i      (cnt),
    .period_o   (period),
    .auto_clr_o (auto_clr),
    .flag_w1c_o (flag_w1c)
  );

  wdg_twostage_cnt #(.CNT_W(CNT_W), .PERIOD_RST(PERIOD_RST)) i_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick_i),
    .kick_i    (kick_i),
    .hold_i    (sys_rst_o),
    .restore_i (restore),
    .period_i  (period),
    .cnt_o     (cnt),
    .reload_o  (reload_val),
    .expire_o  (expire)
  );

  wdg_twostage_seq #(.RST_CYCLES(RST_CYCLES)) i_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .expire_i   (expire),
    .auto_clr_i (auto_clr),
    .flag_w1c_i (flag_w1c),
    .flag_o     (flag),
    .smi_o      (smi_o),
    .sys_rst_o  (sys_rst_o),
    .restore_o  (restore)
  );
endmodule

// File: rtl/wdg_twostage_chk.sv
module wdg_twostage_chk #(
  parameter int unsigned CNT_W      = 16,
  parameter int unsigned RST_CYCLES = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             tick_i,
  input logic             kick_i,
  input logic             smi_o,
  input logic             sys_rst_o,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] reload_val,
  input logic             flag,
  input logic             auto_clr
);
  int unsigned hi_len;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        hi_len <= 0;
    else if (sys_rst_o) hi_len <= hi_len + 1;
    else                hi_len <= 0;
  end

  // R2
  cnt_dec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i && !kick_i && !sys_rst_o && (cnt != '0) |=> cnt == CNT_W'($past(cnt) - 1'b1));

  // R7
  smi_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    smi_o |=> !smi_o);

  // R7
  smi_clears_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    smi_o |=> !flag);

  // R7
  auto_no_rst_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sys_rst_o) |-> !$past(auto_clr));

  // R8
  kick_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    kick_i && !sys_rst_o |=> !smi_o && !$rose(sys_rst_o));

  // R6
  rst_len_max_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sys_rst_o |-> hi_len < RST_CYCLES);

  // R6
  rst_len_full_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sys_rst_o) |-> hi_len == RST_CYCLES);

  // R6
  rst_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sys_rst_o) |-> (cnt == reload_val) && !flag);
endmodule

bind wdg_twostage wdg_twostage_chk #(.CNT_W(CNT_W), .RST_CYCLES(RST_CYCLES)) i_wdg_twostage_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .tick_i     (tick_i),
  .kick_i     (kick_i),
  .smi_o      (smi_o),
  .sys_rst_o  (sys_rst_o),
  .cnt        (cnt),
  .reload_val (reload_val),
  .flag       (flag),
  .auto_clr   (auto_clr)
);

// File: tb/test_wdg_twostage.sv
`timescale 1ns/1ps
module test_wdg_twostage;
  localparam int unsigned CNT_W   = 16;
  localparam int unsigned P_RST   = 20;
  localparam int unsigned RST_CYC = 4;
  localparam int unsigned PER     = 3;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_we_i = 1'b0;
  logic [1:0]  reg_addr_i = 2'd0;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;
  logic        kick_i = 1'b0;
  logic        tick_i = 1'b0;
  logic        smi_o;
  logic        sys_rst_o;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done   = 1'b0;

  always #10 clk_i = ~clk_i;

  wdg_twostage #(.CNT_W(CNT_W), .PERIOD_RST(P_RST), .RST_CYCLES(RST_CYC)) i_wdg_twostage (
    .clk_i(clk_i), .rst_ni(rst_ni), .reg_we_i(reg_we_i), .reg_addr_i(reg_addr_i),
    .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o), .kick_i(kick_i),
    .tick_i(tick_i), .smi_o(smi_o), .sys_rst_o(sys_rst_o)
  );

  always @(posedge clk_i) begin
    cycles <= cycles + 1;
    if (cycles >= 100000 && !done) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog timeout at cycle %0d", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  function automatic int unsigned eff_period(input int unsigned p);
    return (p == 0) ? 1 : p;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic step(input logic t, input logic k);
    tick_i = t;
    kick_i = k;
    @(posedge clk_i);
    #1;
    tick_i = 1'b0;
    kick_i = 1'b0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(posedge clk_i);
    #1;
    reg_we_i = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    reg_addr_i = a;
    #1;
    d = reg_rdata_o;
  endtask

  initial begin
    logic [31:0] v;
    int unsigned m;
    logic exp_smi;
    void'($urandom(32'd20240611));

    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;
    @(posedge clk_i); #1;

    // R1 reset state
    chk("R1 smi", smi_o, 0);
    chk("R1 rst", sys_rst_o, 0);
    rd(2'd0, v); chk("R1 ctrl", v, 32'h2000);
    rd(2'd1, v); chk("R1 status", v, 0);
    rd(2'd2, v); chk("R1 period", v, P_RST);
    rd(2'd3, v); chk("R1 count", v, P_RST);

    // R10 period write leaves count alone
    wr(2'd2, PER);
    rd(2'd3, v); chk("R10 count", v, P_RST);
    // R8 kick reloads
    step(0, 1);
    rd(2'd3, v); chk("R8 reload", v, PER);
    // R2 decrement and hold
    step(1, 0);
    rd(2'd3, v); chk("R2 dec", v, PER - 1);
    step(0, 0);
    rd(2'd3, v); chk("R2 hold", v, PER - 1);

    // R3/R4 first expiry, software owns the flag
    wr(2'd0, 32'h0);
    step(1, 0); step(1, 0);
    rd(2'd3, v); chk("R3 zero", v, 0);
    step(1, 0);
    chk("R4 smi", smi_o, 0);
    chk("R4 rst", sys_rst_o, 0);
    rd(2'd3, v); chk("R3 reload", v, PER);
    rd(2'd1, v); chk("R4 flag", v, 32'h8);

    // R5 write-1-to-clear
    wr(2'd1, 32'h0);
    rd(2'd1, v); chk("R5 w0", v, 32'h8);
    wr(2'd1, 32'h8);
    rd(2'd1, v); chk("R5 w1", v, 0);

    // R11 long window, flag clear at kick
    step(0, 1);
    for (int i = 1; i <= 2 * (PER + 1); i++) begin
      step(1, 0);
      chk("R11 long", sys_rst_o, (i == 2 * (PER + 1)));
    end
    // R9/R6 pulse length with inputs ignored
    for (int j = 1; j < RST_CYC; j++) begin
      step(1, 1);
      chk("R6 pulse", sys_rst_o, 1);
      rd(2'd3, v); chk("R9 count held", v, PER);
    end
    step(0, 0);
    chk("R6 end", sys_rst_o, 0);
    rd(2'd1, v); chk("R6 flag", v, 0);
    rd(2'd3, v); chk("R6 count", v, PER);
    rd(2'd0, v); chk("R6 ctrl", v, 0);
    rd(2'd2, v); chk("R6 period", v, PER);

    // R11 short window, flag left set
    for (int i = 0; i < PER + 1; i++) step(1, 0);
    rd(2'd1, v); chk("R11 flag", v, 32'h8);
    step(0, 1);
    rd(2'd1, v); chk("R11 flag kept", v, 32'h8);
    for (int i = 1; i <= PER + 1; i++) begin
      step(1, 0);
      chk("R11 short", sys_rst_o, (i == PER + 1));
    end
    for (int j = 1; j < RST_CYC; j++) step(0, 0);
    step(0, 0);
    chk("R6 end2", sys_rst_o, 0);

    // R5 expiry outranks clear on same edge
    for (int i = 0; i < PER; i++) step(1, 0);
    reg_we_i = 1'b1; reg_addr_i = 2'd1; reg_wdata_i = 32'h8;
    step(1, 0);
    reg_we_i = 1'b0;
    rd(2'd1, v); chk("R5 set wins", v, 32'h8);
    wr(2'd1, 32'h8);

    // R8 kick beats expiry
    for (int i = 0; i < PER; i++) step(1, 0);
    step(1, 1);
    chk("R8 no smi", smi_o, 0);
    rd(2'd1, v); chk("R8 no flag", v, 0);
    rd(2'd3, v); chk("R8 count", v, PER);

    // R3 zero period reloads as one
    wr(2'd2, 32'h0);
    step(0, 1);
    rd(2'd3, v); chk("R3 zero period", v, eff_period(0));
    wr(2'd2, PER);
    step(0, 1);

    // R7 auto-clear pulse
    wr(2'd0, 32'h2000);
    for (int i = 0; i < PER; i++) step(1, 0);
    step(1, 0);
    chk("R7 smi", smi_o, 1);
    chk("R7 rst", sys_rst_o, 0);
    rd(2'd1, v); chk("R7 flag up", v, 32'h8);
    step(0, 0);
    chk("R7 smi once", smi_o, 0);
    rd(2'd1, v); chk("R7 flag cleared", v, 0);

    // R7 flag already set when auto-clear is enabled
    wr(2'd0, 32'h0);
    for (int i = 0; i < PER + 1; i++) step(1, 0);
    rd(2'd1, v); chk("R7 preset flag", v, 32'h8);
    wr(2'd0, 32'h2000);
    for (int i = 0; i < PER + 1; i++) step(1, 0);
    chk("R7 preset smi", smi_o, 1);
    chk("R7 preset no rst", sys_rst_o, 0);
    step(0, 0);
    rd(2'd1, v); chk("R7 preset cleared", v, 0);

    // random phase, auto-clear on, model predicts count and smi
    step(0, 1);
    m = PER;
    reg_addr_i = 2'd3;
    for (int n = 0; n < 2000; n++) begin
      logic t, k;
      t = ($urandom % 2) == 0;
      k = ($urandom % 20) == 0;
      exp_smi = 1'b0;
      if (k) m = eff_period(PER);
      else if (t) begin
        if (m == 0) begin m = eff_period(PER); exp_smi = 1'b1; end
        else m = m - 1;
      end
      step(t, k);
      rd(2'd3, v); chk("R2 rand count", v, m);
      chk("R7 rand smi", smi_o, exp_smi);
      chk("R7 rand rst", sys_rst_o, 0);
    end

    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule